// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer

This block produces the two gate enables of a half-bridge: `gate_hi` for the upper switch and `gate_lo` for the lower switch. A supply monitor with hysteresis holds the bridge in a start-up state until a digitized supply level is high enough. During start-up the lower switch is held on so that the bootstrap capacitor of the upper driver can charge. Once the supply is adequate, the block runs normally. It returns to start-up when the supply sags to or below a lower stop threshold.

In normal operation a static select input picks one of two modes. In direct mode, independent high and low requests pass through a cross-conduction interlock. In clocked mode, a single phase input drives complementary outputs. A programmable number of cycles with both gates off is inserted at every phase change, and a shutdown input forces both gates off. The phase and request inputs first pass through a two-flop synchronizer, and both gate outputs are registered.

The block has no data stream, so it has no valid/ready handshake. Every pin is a plain level.

Top module: `hb_gate_ctrl`

## Requirements
- R1: During reset and in start-up, `gate_hi` is 0 and `gate_lo` is 1.
- R2: Start-up ends when `vdd_lvl >= vdd_on_th` at a clock edge. The outputs show normal operation from the second edge after the level is applied.
- R3: In normal operation, `vdd_lvl <= vdd_off_th` returns the block to start-up, and `gate_lo=1` is visible two edges later. While `vdd_off_th < vdd_lvl < vdd_on_th`, the current state is kept.
- R4: A change on `in_a` or `in_b` reaches the gate outputs on the third rising edge after it is applied, and not before.
- R5: In direct mode (`mode_clocked=0`), `in_a` is the high request and `in_b` is the low request. The input pair (a,b)=00 gives both gates off, 01 gives `gate_lo=1`, and 10 gives `gate_hi=1`.
- R6: In direct mode, (a,b)=11 forces both gates off.
- R7: In clocked mode (`mode_clocked=1`) with `in_b` (shutdown) at 0, phase `in_a=0` selects `gate_lo` and `in_a=1` selects `gate_hi`.
- R8: In clocked mode, every phase change gives exactly `dt_cycles` cycles with both gates off before the new side turns on. With `dt_cycles=0` the switch-over takes place in one cycle.
- R9: In clocked mode, `in_b=1` forces both gates off. After it is released, both gates stay off for `dt_cycles` cycles before the selected side turns on. Entering start-up clears the dead-time state.
- R10: `gate_hi` and `gate_lo` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vdd_lvl | input | SUPPLY_W | Digitized supply level, synchronous to clk |
| vdd_on_th | input | SUPPLY_W | Level that ends start-up |
| vdd_off_th | input | SUPPLY_W | Level at or below which start-up is re-entered |
| mode_clocked | input | 1 | 0 = direct mode, 1 = clocked mode |
| in_a | input | 1 | High request (direct mode) or phase (clocked mode) |
| in_b | input | 1 | Low request (direct mode) or shutdown (clocked mode) |
| dt_cycles | input | DT_W | Non-overlap length in clock cycles |
| gate_hi | output | 1 | Upper switch enable |
| gate_lo | output | 1 | Lower switch enable |

## Verification
The assertions take the following as given about the inputs:
- `mode_clocked` changes only while the block is in start-up.
- `vdd_off_th` is below `vdd_on_th`.
- `vdd_lvl` is already synchronous to `clk`.
- `dt_cycles` does not change in the middle of a non-overlap interval, because the gap check relies on its current value.

The stimulus follows all of these rules. It switches mode only after pulling the supply below the stop level. It keeps the thresholds fixed at 200 and 100. It changes `dt_cycles` only together with a phase edge, after any earlier gap has finished.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic {
    ST_START = 1'b0,
    ST_RUN   = 1'b1
  } hb_state_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hb_supply_fsm.sv
module hb_supply_fsm
  import hb_pkg::*;
#(
  parameter int unsigned SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] lvl,
  input  logic [SW-1:0] on_th,
  input  logic [SW-1:0] off_th,
  output logic          run
);
  hb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_START: if (lvl >= on_th)  state_d = ST_RUN;
      ST_RUN:   if (lvl <= off_th) state_d = ST_START;
      default:  state_d = ST_START;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_START;
    else        state_q <= state_d;
  end

  assign run = (state_q == ST_RUN);
endmodule

// File: rtl/hb_direct.sv
module hb_direct (
  input  logic req_hi,
  input  logic req_lo,
  output logic hi,
  output logic lo
);
  // Interlock: both requests at once yields neither gate.
  assign hi = req_hi & ~req_lo;
  assign lo = req_lo & ~req_hi;
endmodule

// File: rtl/hb_deadtime.sv
module hb_deadtime #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          phase,
  input  logic          sd,
  input  logic [DW-1:0] dt,
  output logic          hi,
  output logic          lo
);
  logic          prev_q;
  logic [DW-1:0] gap_q;
  logic          edge_w;
  logic          dt_zero;
  logic          allow;

  assign edge_w  = (phase != prev_q);
  assign dt_zero = (dt == '0);

  // The edge cycle counts as the first gap cycle, so an edge reloads dt-1.
  // Shutdown holds a full dt, so recovery spends dt cycles off.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      gap_q  <= '0;
    end else if (!en) begin
      prev_q <= phase;
      gap_q  <= '0;
    end else if (sd) begin
      prev_q <= phase;
      gap_q  <= dt;
    end else if (edge_w) begin
      prev_q <= phase;
      gap_q  <= dt_zero ? '0 : dt - 1'b1;
    end else if (gap_q != '0) begin
      gap_q  <= gap_q - 1'b1;
    end
  end

  always_comb begin
    if (!en || sd)   allow = 1'b0;
    else if (edge_w) allow = dt_zero && (gap_q == '0);
    else             allow = (gap_q == '0);
  end

  assign hi = allow & phase;
  assign lo = allow & ~phase;
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl #(
  parameter int unsigned SUPPLY_W = 8,
  parameter int unsigned DT_W     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SUPPLY_W-1:0] vdd_lvl,
  input  logic [SUPPLY_W-1:0] vdd_on_th,
  input  logic [SUPPLY_W-1:0] vdd_off_th,
  input  logic                mode_clocked,
  input  logic                in_a,
  input  logic                in_b,
  input  logic [DT_W-1:0]     dt_cycles,
  output logic                gate_hi,
  output logic                gate_lo
);
  localparam int unsigned NSYNC = 2;

  logic [NSYNC-1:0] sync_q;
  logic a_sync, b_sync;
  logic run_w;
  logic dir_hi, dir_lo;
  logic dt_hi, dt_lo;
  logic hi_d, lo_d;

  hb_sync #(.W(NSYNC), .STAGES(hb_pkg::SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({in_b, in_a}), .q(sync_q)
  );
  assign a_sync = sync_q[0];
  assign b_sync = sync_q[1];

  hb_supply_fsm #(.SW(SUPPLY_W)) u_supply (
    .clk(clk), .rst_n(rst_n), .lvl(vdd_lvl),
    .on_th(vdd_on_th), .off_th(vdd_off_th), .run(run_w)
  );

  hb_direct u_direct (
    .req_hi(a_sync), .req_lo(b_sync), .hi(dir_hi), .lo(dir_lo)
  );

  hb_deadtime #(.DW(DT_W)) u_dead (
    .clk(clk), .rst_n(rst_n), .en(run_w & mode_clocked),
    .phase(a_sync), .sd(b_sync), .dt(dt_cycles),
    .hi(dt_hi), .lo(dt_lo)
  );

  always_comb begin
    if (!run_w) begin
      hi_d = 1'b0;
      lo_d = 1'b1;
    end else if (mode_clocked) begin
      hi_d = dt_hi;
      lo_d = dt_lo;
    end else begin
      hi_d = dir_hi;
      lo_d = dir_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b1;
    end else begin
      gate_hi <= hi_d;
      gate_lo <= lo_d;
    end
  end
endmodule

// File: rtl/hb_gate_ctrl_chk.sv
module hb_gate_ctrl_chk #(
  parameter int unsigned SW = 8,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [SW-1:0] vdd_lvl,
  input logic [SW-1:0] vdd_on_th,
  input logic [SW-1:0] vdd_off_th,
  input logic          mode_clocked,
  input logic [DW-1:0] dt_cycles,
  input logic          run_q,
  input logic          a_s,
  input logic          b_s,
  input logic          gate_hi,
  input logic          gate_lo
);
  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo)); // R10

  AST_STARTUP_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (!gate_hi && gate_lo)); // R1

  AST_STARTUP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && vdd_lvl >= vdd_on_th) |=> run_q); // R2

  AST_STARTUP_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && vdd_lvl <= vdd_off_th) |=> !run_q); // R3

  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && vdd_lvl > vdd_off_th) |=> run_q); // R3

  AST_DIRECT_INTERLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !mode_clocked && a_s && b_s) |=> (!gate_hi && !gate_lo)); // R6

  AST_SHUTDOWN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && mode_clocked && b_s) |=> (!gate_hi && !gate_lo)); // R9

  AST_GAP_BEFORE_HI: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hi) && mode_clocked && dt_cycles != '0 && $past(run_q, 2))
      |-> !$past(gate_lo)); // R8
endmodule

bind hb_gate_ctrl hb_gate_ctrl_chk #(.SW(SUPPLY_W), .DW(DT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vdd_lvl(vdd_lvl), .vdd_on_th(vdd_on_th),
  .vdd_off_th(vdd_off_th), .mode_clocked(mode_clocked), .dt_cycles(dt_cycles),
  .run_q(run_w), .a_s(a_sync), .b_s(b_sync),
  .gate_hi(gate_hi), .gate_lo(gate_lo)
);

// File: tb/hb_gate_ctrl_test.sv
module hb_gate_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] vdd_lvl = 8'd0;
  logic [7:0] vdd_on_th = 8'd200;
  logic [7:0] vdd_off_th = 8'd100;
  logic       mode_clocked = 1'b0;
  logic       in_a = 1'b0;
  logic       in_b = 1'b0;
  logic [7:0] dt_cycles = 8'd4;
  logic       gate_hi, gate_lo;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    int    due;
    bit    hi;
    bit    lo;
    string req;
  } exp_t;
  exp_t sb[$];

  hb_gate_ctrl uut (
    .clk(clk), .rst_n(rst_n), .vdd_lvl(vdd_lvl), .vdd_on_th(vdd_on_th),
    .vdd_off_th(vdd_off_th), .mode_clocked(mode_clocked), .in_a(in_a),
    .in_b(in_b), .dt_cycles(dt_cycles), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Push an expected output pair due k edges after the current point.
  task automatic expect_at(int k, bit hi, bit lo, string req);
    exp_t e;
    e.due = cyc + k; e.hi = hi; e.lo = lo; e.req = req;
    sb.push_back(e);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares due items, and checks for overlap every cycle (R10).
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (gate_hi && gate_lo) begin
        fails++;
        $display("FAIL R10 cyc=%0d actual hi=%0b lo=%0b expected not both 1", cyc, gate_hi, gate_lo);
      end
    end
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        checks++;
        if (gate_hi !== sb[i].hi || gate_lo !== sb[i].lo) begin
          fails++;
          $display("FAIL %s cyc=%0d actual hi=%0b lo=%0b expected hi=%0b lo=%0b",
                   sb[i].req, cyc, gate_hi, gate_lo, sb[i].hi, sb[i].lo);
        end
        sb.delete(i);
      end
    end
  end

  initial begin
    wait_cyc(200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    checks++;
    if (gate_hi !== 1'b0 || gate_lo !== 1'b1) begin
      fails++;
      $display("FAIL R1 in reset actual hi=%0b lo=%0b expected hi=0 lo=1", gate_hi, gate_lo);
    end
    rst_n = 1'b1;
    expect_at(1, 0, 1, "R1");
    // Supply below the start level: the block stays in start-up despite a high request.
    vdd_lvl = 8'd150; in_a = 1'b1;
    expect_at(4, 0, 1, "R1");
    wait_cyc(5);
    // R2: supply at the start level; gate_hi appears on the second edge.
    vdd_lvl = 8'd200;
    expect_at(1, 0, 1, "R2");
    expect_at(2, 1, 0, "R2");
    wait_cyc(4);
    // R4 and R5: the low request arrives on the third edge.
    in_a = 1'b0; in_b = 1'b1;
    expect_at(2, 1, 0, "R4");
    expect_at(3, 0, 1, "R5");
    wait_cyc(4);
    in_b = 1'b0;
    expect_at(3, 0, 0, "R5");
    wait_cyc(4);
    in_a = 1'b1; in_b = 1'b1;
    expect_at(3, 0, 0, "R6");
    wait_cyc(4);
    in_b = 1'b0;
    expect_at(3, 1, 0, "R5");
    wait_cyc(4);
    // R3: hysteresis.
    vdd_lvl = 8'd150;
    expect_at(3, 1, 0, "R3");
    wait_cyc(4);
    vdd_lvl = 8'd100;
    expect_at(1, 1, 0, "R3");
    expect_at(2, 0, 1, "R3");
    wait_cyc(3);
    vdd_lvl = 8'd150;
    expect_at(3, 0, 1, "R3");
    wait_cyc(4);
    // Clocked mode is selected while in start-up.
    vdd_lvl = 8'd50; mode_clocked = 1'b1; in_a = 1'b0; in_b = 1'b0; dt_cycles = 8'd4;
    wait_cyc(5);
    vdd_lvl = 8'd250;
    expect_at(2, 0, 1, "R7");
    wait_cyc(5);
    // R8: phase 0->1 with a 4-cycle gap.
    in_a = 1'b1;
    expect_at(3, 0, 0, "R8");
    expect_at(6, 0, 0, "R8");
    expect_at(7, 1, 0, "R7");
    wait_cyc(9);
    // R8: zero gap switches in one cycle.
    in_a = 1'b0; dt_cycles = 8'd0;
    expect_at(2, 1, 0, "R4");
    expect_at(3, 0, 1, "R8");
    wait_cyc(5);
    in_a = 1'b1; dt_cycles = 8'd2;
    expect_at(3, 0, 0, "R8");
    expect_at(4, 0, 0, "R8");
    expect_at(5, 1, 0, "R8");
    wait_cyc(7);
    // R9: shutdown, then recovery.
    in_b = 1'b1;
    expect_at(3, 0, 0, "R9");
    wait_cyc(4);
    in_a = 1'b0;
    expect_at(3, 0, 0, "R9");
    wait_cyc(5);
    in_b = 1'b0;
    expect_at(4, 0, 0, "R9");
    expect_at(5, 0, 1, "R9");
    wait_cyc(8);
    // R9: re-entering start-up clears the gap, so the next run resumes at once.
    vdd_lvl = 8'd80;
    expect_at(2, 0, 1, "R9");
    wait_cyc(3);
    in_a = 1'b1; dt_cycles = 8'd6;
    wait_cyc(4);
    vdd_lvl = 8'd220;
    expect_at(2, 1, 0, "R9");
    wait_cyc(4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule